// File: doc/BRIEF.md
# E1 Multiframe E-Bit Insertion and Remote Error Monitor

This block handles the two E-bit slots of a 16-frame E1 CRC-4 multiframe on both sides of a framer. On the transmit side it chooses the bit placed in the E-bit slot of frames 13 and 15. The slot in frame 13 reports submultiframe I (frames 0 to 7). The slot in frame 15 reports submultiframe II (frames 8 to 15). A 1 in a slot means that submultiframe arrived without a CRC error, and a 0 means it had one.

The transmitted value comes from one of several sources:
- status bits that software stages and that take effect only at a multiframe boundary;
- the latest received CRC-4 compare result for the matching submultiframe, fed back automatically;
- a transparent bit taken from the system-side stream.

While the receiver has not reached multiframe alignment, a configured constant is sent instead.

On the receive side the block counts zeros arriving in the same two slots, which is the remote end's report on the quality of this end's transmit line. The count runs only while the receiver is in multiframe sync. The count saturates at all-ones. A snapshot strobe moves the count to an output register and restarts the running count in the same cycle. The block also gives one-cycle multiframe-begin strobes for both directions. CRC-4 computation and frame alignment search are done elsewhere.

Top module: `e1_ebit_unit`

## Requirements
- R1: `tx_ebit` carries the submultiframe I status when `tx_fnum` is 13 and the submultiframe II status when `tx_fnum` is 15. For every other frame number it is 1.
- R2: In manual mode, a cycle with `sw_wr` high stages `sw_e13` and `sw_e15`. The staged bits reach `tx_ebit` only at a multiframe begin: `tx_fstb` with `tx_fnum`=0 when `cfg_upd_rx`=0, or `rx_fstb` with `rx_fnum`=0 when `cfg_upd_rx`=1. A begin event of the other direction does not load them.
- R3: In automatic mode (`cfg_auto`=1, `cfg_transp`=0, multiframe sync), a slot sends the inverse of the last `rx_crc_err` latched for its submultiframe. `rx_crc_smf`=0 selects I and 1 selects II.
- R4: With `cfg_transp`=1 in multiframe sync, `tx_ebit` in frames 13 and 15 equals `sys_ebit`, whatever `cfg_auto` says.
- R5: When `sync_state` is not 2'b10 (multiframe sync), `tx_ebit` in frames 13 and 15 equals `cfg_async_one`, whatever the mode bits say. The codes are 2'b00 for no alignment, 2'b01 for double-frame only and 2'b11 for reserved.
- R6: The running count rises by one in the cycle after `rx_fstb` is high with `rx_fnum` equal to 13 or 15, `rx_ebit`=0 and `sync_state`=2'b10. It does not change for any other combination.
- R7: The running count saturates at all-ones (0xFFFF at the default width) and never wraps.
- R8: A cycle with `snap` high loads `err_count` with the running count plus any increment of that same cycle, and clears the running count. No increment is lost or counted twice.
- R9: `tx_mfb` (`rx_mfb`) is high for exactly the one cycle after `tx_fstb` (`rx_fstb`) is sampled high with frame number 0.
- R10: After reset, `err_count` is 0 and both strobes are low. The staged, active and latched status bits all read 1 (no error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_state | input | 2 | Receiver alignment state: 00 none, 01 double-frame, 10 multiframe, 11 reserved |
| cfg_auto | input | 1 | Feed received CRC status into transmit E bits |
| cfg_transp | input | 1 | Take transmit E bits from `sys_ebit` |
| cfg_async_one | input | 1 | Value of transmit E bits while not in multiframe sync |
| cfg_upd_rx | input | 1 | Apply staged software bits on receive (1) or transmit (0) multiframe begin |
| sw_wr | input | 1 | Stage `sw_e13` and `sw_e15` |
| sw_e13 | input | 1 | Software status for the frame 13 slot |
| sw_e15 | input | 1 | Software status for the frame 15 slot |
| sys_ebit | input | 1 | System-side transparent E bit |
| tx_fstb | input | 1 | Transmit frame start strobe |
| tx_fnum | input | FNUM_W | Transmit frame number within the multiframe |
| rx_fstb | input | 1 | Receive frame start strobe; `rx_ebit` valid with it |
| rx_fnum | input | FNUM_W | Receive frame number within the multiframe |
| rx_ebit | input | 1 | Received bit in the E-bit position |
| rx_crc_valid | input | 1 | A submultiframe CRC compare result is ready |
| rx_crc_smf | input | 1 | Submultiframe of that result: 0 = I, 1 = II |
| rx_crc_err | input | 1 | The result was a CRC mismatch |
| snap | input | 1 | Snapshot the error count and clear the running count |
| tx_ebit | output | 1 | Transmit E-bit value for the current transmit frame |
| err_count | output | CNT_W | Last snapshot of the received zero E-bit count |
| tx_mfb | output | 1 | Transmit multiframe begin strobe |
| rx_mfb | output | 1 | Receive multiframe begin strobe |

## Verification
The bench sweeps every transmit frame number against every sync code and every combination of transparency, automatic mode, async value and system bit. The staged, latched and transparent sources are set to differ, so a wrong priority or a swapped slot gives a visibly wrong bit. Every receive frame number, E-bit value and sync code is followed by a snapshot. A counter that counted outside frames 13 and 15, counted ones, or ran outside multiframe sync would show a nonzero count where none is due. The bench also fires a snapshot in the same cycle as an increment, and drives the counter past all-ones at a reduced width. These cases catch a lost or doubled increment and a wrap to zero. Staged software bits are probed after a begin event of the wrong direction, to catch a load on the wrong boundary or an immediate load.

// File: rtl/ebit_pkg.sv
// Package: shared types and helpers for the E1 E-bit unit.
// Assumes a CRC-4 multiframe of MF_LEN frames whose E-bit slots sit in
// the third-last and the last frame (13 and 15 for 16 frames).
package ebit_pkg;

    // Receiver alignment state as seen on sync_state.
    typedef enum logic [1:0] {
        SYNC_NONE = 2'b00,
        SYNC_DF   = 2'b01,
        SYNC_MF   = 2'b10,
        SYNC_RSVD = 2'b11
    } sync_e;

    // Number of E-bit slots (one per submultiframe).
    localparam int N_SLOTS = 2;

    // Frame number carrying E-bit slot idx in a multiframe of mf_len frames.
    function automatic int slot_frame(input int mf_len, input int idx);
        return mf_len - 3 + 2 * idx;
    endfunction

endpackage

// File: rtl/ebit_mf_strobe.sv
// Module: ebit_mf_strobe
// Turns a frame-start strobe whose frame number is zero into a registered
// one-cycle multiframe-begin pulse. Assumes fnum is valid whenever fstb is high.
module ebit_mf_strobe #(
    parameter int FNUM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fstb,
    input  logic [FNUM_W-1:0] fnum,
    output logic              mfb
);

    logic begin_now;

    // Detect the first frame of a multiframe.
    always_comb begin
        begin_now = fstb && (fnum == '0);
    end

    // Register the pulse so it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfb <= 1'b0;
        end else begin
            mfb <= begin_now;
        end
    end

endmodule

// File: rtl/ebit_slot_store.sv
// Module: ebit_slot_store
// Holds, per E-bit slot, the software status (staged and active copies) and
// the last received CRC-4 result of the matching submultiframe.
// Assumes apply is a single-cycle multiframe-begin event. A write in the
// same cycle as apply lands in the stage and goes out at the next boundary.
module ebit_slot_store #(
    parameter int N = 2,
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [N-1:0]     sw_val,
    input  logic             apply,
    input  logic             crc_valid,
    input  logic [SEL_W-1:0] crc_sel,
    input  logic             crc_err,
    output logic [N-1:0]     man_val,
    output logic [N-1:0]     auto_val
);

    logic [N-1:0] stage_q;

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Stage the software value for this slot on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= 1'b1;
            end else if (sw_wr) begin
                stage_q[g] <= sw_val[g];
            end
        end

        // Move the staged value to the active copy at a multiframe boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                man_val[g] <= 1'b1;
            end else if (apply) begin
                man_val[g] <= stage_q[g];
            end
        end

        // Latch the newest CRC result for this submultiframe (1 = no error).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                auto_val[g] <= 1'b1;
            end else if (crc_valid && (crc_sel == SEL_W'(g))) begin
                auto_val[g] <= ~crc_err;
            end
        end
    end

endmodule

// File: rtl/ebit_tx_select.sv
// Module: ebit_tx_select
// Combinational choice of the transmit E-bit for the current transmit frame.
// Outside the slot frames the output is 1. Outside multiframe sync a slot
// carries the async constant. In sync, transparency beats automatic, and
// automatic beats the active software bits.
module ebit_tx_select #(
    parameter int FNUM_W = 4,
    parameter int MF_LEN = 16,
    parameter int N      = 2
) (
    input  logic [FNUM_W-1:0] fnum,
    input  logic              in_mf_sync,
    input  logic              async_one,
    input  logic              transp,
    input  logic              auto_en,
    input  logic              sys_bit,
    input  logic [N-1:0]      man_val,
    input  logic [N-1:0]      auto_val,
    output logic              ebit
);

    logic [N-1:0] hit;
    logic         slot_man;
    logic         slot_auto;
    logic         any_hit;

    for (genvar g = 0; g < N; g++) begin : g_hit
        localparam int FRAME = ebit_pkg::slot_frame(MF_LEN, g);
        // Flag the frame that carries slot g.
        always_comb begin
            hit[g] = (fnum == FNUM_W'(FRAME));
        end
    end

    // Pick the software and automatic values of the slot being sent.
    always_comb begin
        slot_man  = 1'b1;
        slot_auto = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                slot_man  = man_val[i];
                slot_auto = auto_val[i];
            end
        end
        any_hit = |hit;
    end

    // Apply the sync-state gate and the source priority.
    always_comb begin
        if (!any_hit) begin
            ebit = 1'b1;
        end else if (!in_mf_sync) begin
            ebit = async_one;
        end else if (transp) begin
            ebit = sys_bit;
        end else if (auto_en) begin
            ebit = slot_auto;
        end else begin
            ebit = slot_man;
        end
    end

endmodule

// File: rtl/ebit_err_counter.sv
// Module: ebit_err_counter
// Counts zeros received in the E-bit slots while in multiframe sync. The
// count saturates at all-ones. snap copies the count, including an increment
// of the same cycle, to the output register and restarts the count.
module ebit_err_counter #(
    parameter int CNT_W  = 16,
    parameter int FNUM_W = 4,
    parameter int MF_LEN = 16,
    parameter int N      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_fstb,
    input  logic [FNUM_W-1:0] rx_fnum,
    input  logic              rx_ebit,
    input  logic              in_mf_sync,
    input  logic              snap,
    output logic [CNT_W-1:0]  run_cnt,
    output logic [CNT_W-1:0]  snap_cnt
);

    logic [N-1:0]     slot_hit;
    logic             inc;
    logic [CNT_W-1:0] cnt_next;

    for (genvar g = 0; g < N; g++) begin : g_hit
        localparam int FRAME = ebit_pkg::slot_frame(MF_LEN, g);
        // Flag a received frame that carries slot g.
        always_comb begin
            slot_hit[g] = (rx_fnum == FNUM_W'(FRAME));
        end
    end

    // Qualify an increment and compute the saturated next count.
    always_comb begin
        inc      = rx_fstb && (|slot_hit) && !rx_ebit && in_mf_sync;
        cnt_next = run_cnt;
        if (inc && !(&run_cnt)) begin
            cnt_next = run_cnt + 1'b1;
        end
    end

    // Running count: restart on snap, otherwise take the next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (snap) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= cnt_next;
        end
    end

    // Snapshot register, loaded with the count including this cycle's event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_cnt <= '0;
        end else if (snap) begin
            snap_cnt <= cnt_next;
        end
    end

endmodule

// File: rtl/e1_ebit_unit.sv
// Module: e1_ebit_unit (top)
// Transmit E-bit insertion and received E-bit error monitor for an E1
// CRC-4 multiframe. Assumes frame strobes come one per frame with valid
// frame numbers, and CRC results come at the end of each submultiframe.
module e1_ebit_unit #(
    parameter int CNT_W  = 16,
    parameter int FNUM_W = 4,
    parameter int MF_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sync_state,
    input  logic              cfg_auto,
    input  logic              cfg_transp,
    input  logic              cfg_async_one,
    input  logic              cfg_upd_rx,
    input  logic              sw_wr,
    input  logic              sw_e13,
    input  logic              sw_e15,
    input  logic              sys_ebit,
    input  logic              tx_fstb,
    input  logic [FNUM_W-1:0] tx_fnum,
    input  logic              rx_fstb,
    input  logic [FNUM_W-1:0] rx_fnum,
    input  logic              rx_ebit,
    input  logic              rx_crc_valid,
    input  logic              rx_crc_smf,
    input  logic              rx_crc_err,
    input  logic              snap,
    output logic              tx_ebit,
    output logic [CNT_W-1:0]  err_count,
    output logic              tx_mfb,
    output logic              rx_mfb
);
    import ebit_pkg::*;

    localparam int NS = N_SLOTS;

    logic          in_mf_sync;
    logic          tx_begin;
    logic          rx_begin;
    logic          apply;
    logic [NS-1:0] sw_val;
    logic [NS-1:0] man_val;
    logic [NS-1:0] auto_val;
    logic [CNT_W-1:0] run_cnt;

    // Decode sync state, begin events and the software vector.
    always_comb begin
        in_mf_sync = (sync_e'(sync_state) == SYNC_MF);
        tx_begin   = tx_fstb && (tx_fnum == '0);
        rx_begin   = rx_fstb && (rx_fnum == '0);
        apply      = cfg_upd_rx ? rx_begin : tx_begin;
        sw_val     = {sw_e15, sw_e13};
    end

    ebit_mf_strobe #(.FNUM_W(FNUM_W)) tx_mfb_i (
        .clk(clk), .rst_n(rst_n), .fstb(tx_fstb), .fnum(tx_fnum), .mfb(tx_mfb)
    );

    ebit_mf_strobe #(.FNUM_W(FNUM_W)) rx_mfb_i (
        .clk(clk), .rst_n(rst_n), .fstb(rx_fstb), .fnum(rx_fnum), .mfb(rx_mfb)
    );

    ebit_slot_store #(.N(NS)) store_i (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_val(sw_val), .apply(apply),
        .crc_valid(rx_crc_valid), .crc_sel(rx_crc_smf), .crc_err(rx_crc_err),
        .man_val(man_val), .auto_val(auto_val)
    );

    ebit_tx_select #(.FNUM_W(FNUM_W), .MF_LEN(MF_LEN), .N(NS)) sel_i (
        .fnum(tx_fnum), .in_mf_sync(in_mf_sync), .async_one(cfg_async_one),
        .transp(cfg_transp), .auto_en(cfg_auto), .sys_bit(sys_ebit),
        .man_val(man_val), .auto_val(auto_val), .ebit(tx_ebit)
    );

    ebit_err_counter #(.CNT_W(CNT_W), .FNUM_W(FNUM_W), .MF_LEN(MF_LEN), .N(NS)) cnt_i (
        .clk(clk), .rst_n(rst_n),
        .rx_fstb(rx_fstb), .rx_fnum(rx_fnum), .rx_ebit(rx_ebit),
        .in_mf_sync(in_mf_sync), .snap(snap),
        .run_cnt(run_cnt), .snap_cnt(err_count)
    );

endmodule

// File: rtl/ebit_checker.sv
// Module: ebit_checker
// Temporal checks on the E-bit unit, attached to the top with bind.
module ebit_checker #(
    parameter int CNT_W  = 16,
    parameter int FNUM_W = 4,
    parameter int MF_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        sync_state,
    input logic              cfg_async_one,
    input logic              tx_fstb,
    input logic [FNUM_W-1:0] tx_fnum,
    input logic              rx_fstb,
    input logic [FNUM_W-1:0] rx_fnum,
    input logic              snap,
    input logic              tx_ebit,
    input logic              tx_mfb,
    input logic              rx_mfb,
    input logic [CNT_W-1:0]  run_cnt
);
    localparam logic [FNUM_W-1:0] F_A = FNUM_W'(MF_LEN - 3);
    localparam logic [FNUM_W-1:0] F_B = FNUM_W'(MF_LEN - 1);

    logic tx_slot;
    logic not_sync;

    // Helper decodes for the properties.
    always_comb begin
        tx_slot  = (tx_fnum == F_A) || (tx_fnum == F_B);
        not_sync = (sync_state != 2'b10);
    end

    a_r1_idle_one: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_slot |-> tx_ebit);

    a_r5_async_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_slot && not_sync) |-> (tx_ebit == cfg_async_one));

    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> ((run_cnt == $past(run_cnt)) ||
                   (run_cnt == CNT_W'($past(run_cnt) + 1'b1))));

    a_r6_hold_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap && not_sync) |=> $stable(run_cnt));

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap && (&run_cnt)) |=> (&run_cnt));

    a_r8_snap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (run_cnt == '0));

    a_r9_tx_mfb: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fstb && (tx_fnum == '0)) |=> tx_mfb);

    a_r9_tx_mfb_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_fstb && (tx_fnum == '0)) |=> !tx_mfb);

    a_r9_rx_mfb: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fstb && (rx_fnum == '0)) |=> rx_mfb);

    a_r9_rx_mfb_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_fstb && (rx_fnum == '0)) |=> !rx_mfb);

endmodule

bind e1_ebit_unit ebit_checker #(.CNT_W(CNT_W), .FNUM_W(FNUM_W), .MF_LEN(MF_LEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .sync_state(sync_state), .cfg_async_one(cfg_async_one),
    .tx_fstb(tx_fstb), .tx_fnum(tx_fnum), .rx_fstb(rx_fstb), .rx_fnum(rx_fnum),
    .snap(snap), .tx_ebit(tx_ebit), .tx_mfb(tx_mfb), .rx_mfb(rx_mfb),
    .run_cnt(run_cnt)
);

// File: tb/e1_ebit_unit_tb_top.sv
// Bench: sweeps the E-bit selection and the error counter at a 4-bit count width.
module e1_ebit_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int FNUM_W     = 4;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sync_state = 2'b00;
    logic cfg_auto = 0, cfg_transp = 0, cfg_async_one = 0, cfg_upd_rx = 0;
    logic sw_wr = 0, sw_e13 = 1, sw_e15 = 1, sys_ebit = 0;
    logic tx_fstb = 0, rx_fstb = 0, rx_ebit = 1;
    logic [FNUM_W-1:0] tx_fnum = '0, rx_fnum = '0;
    logic rx_crc_valid = 0, rx_crc_smf = 0, rx_crc_err = 0, snap = 0;
    logic tx_ebit, tx_mfb, rx_mfb;
    logic [CNT_W-1:0] err_count;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_ebit_unit #(.CNT_W(CNT_W), .FNUM_W(FNUM_W), .MF_LEN(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_state(sync_state),
        .cfg_auto(cfg_auto), .cfg_transp(cfg_transp), .cfg_async_one(cfg_async_one),
        .cfg_upd_rx(cfg_upd_rx), .sw_wr(sw_wr), .sw_e13(sw_e13), .sw_e15(sw_e15),
        .sys_ebit(sys_ebit), .tx_fstb(tx_fstb), .tx_fnum(tx_fnum),
        .rx_fstb(rx_fstb), .rx_fnum(rx_fnum), .rx_ebit(rx_ebit),
        .rx_crc_valid(rx_crc_valid), .rx_crc_smf(rx_crc_smf), .rx_crc_err(rx_crc_err),
        .snap(snap), .tx_ebit(tx_ebit), .err_count(err_count),
        .tx_mfb(tx_mfb), .rx_mfb(rx_mfb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: inputs set in the low phase, results read at the next low phase.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic snap_read(output int v);
        snap = 1; tick(); snap = 0;
        v = err_count;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        int man13, man15, au13, au15;
        @(negedge clk); tick(); tick();
        rst_n = 1; tick();
        // R10: reset state
        chk("R10 err_count", err_count, 0);
        chk("R10 tx_mfb", tx_mfb, 0);
        chk("R10 rx_mfb", rx_mfb, 0);
        sync_state = 2'b10; tx_fnum = 4'd13; #1;
        chk("R10 active status frame13", tx_ebit, 1);
        cfg_auto = 1; #1;
        chk("R10 latched status frame13", tx_ebit, 1);
        cfg_auto = 0;
        @(negedge clk);

        // R2: stage software bits, wrong-direction begin, then right begin
        sw_wr = 1; sw_e13 = 0; sw_e15 = 1; tick(); sw_wr = 0;
        chk("R2 staged not yet applied", tx_ebit, 1);
        rx_fstb = 1; rx_fnum = 0; rx_ebit = 1; tick(); rx_fstb = 0;
        chk("R2 rx begin ignored with cfg_upd_rx=0", tx_ebit, 1);
        tx_fstb = 1; tx_fnum = 0; tick(); tx_fstb = 0; tx_fnum = 13; #1;
        chk("R2 applied at tx begin", tx_ebit, 0);
        cfg_upd_rx = 1; @(negedge clk);
        sw_wr = 1; sw_e13 = 1; tick(); sw_wr = 0;
        tx_fstb = 1; tx_fnum = 0; tick(); tx_fstb = 0; tx_fnum = 13; #1;
        chk("R2 tx begin ignored with cfg_upd_rx=1", tx_ebit, 0);
        @(negedge clk);
        rx_fstb = 1; rx_fnum = 0; tick(); rx_fstb = 0; #1;
        chk("R2 applied at rx begin", tx_ebit, 1);
        @(negedge clk);
        sw_wr = 1; sw_e13 = 0; sw_e15 = 1; tick(); sw_wr = 0;
        rx_fstb = 1; rx_fnum = 0; tick(); rx_fstb = 0;
        man13 = 0; man15 = 1;

        // R3: latch submultiframe CRC results
        cfg_auto = 1;
        rx_crc_valid = 1; rx_crc_smf = 0; rx_crc_err = 1; tick(); rx_crc_valid = 0;
        tx_fnum = 13; #1;
        chk("R3 smf I error sends 0", tx_ebit, 0);
        tx_fnum = 15; #1;
        chk("R3 smf II untouched", tx_ebit, 1);
        @(negedge clk);
        rx_crc_valid = 1; rx_crc_smf = 0; rx_crc_err = 0; tick();
        rx_crc_smf = 1; rx_crc_err = 1; tick(); rx_crc_valid = 0;
        au13 = 1; au15 = 0;
        tx_fnum = 13; #1;
        chk("R3 smf I latest result", tx_ebit, 1);
        cfg_auto = 0;
        @(negedge clk);

        // R1 R3 R4 R5: exhaustive transmit selection sweep
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 16; f++)
                for (int m = 0; m < 16; m++) begin
                    int exp;
                    string req;
                    sync_state = 2'(s); tx_fnum = 4'(f);
                    cfg_transp = m[0]; cfg_auto = m[1]; cfg_async_one = m[2]; sys_ebit = m[3];
                    #1;
                    if (f != 13 && f != 15) begin exp = 1; req = "R1 idle frame"; end
                    else if (s != 2) begin exp = m[2]; req = "R5 async forced"; end
                    else if (m[0]) begin exp = m[3]; req = "R4 transparent"; end
                    else if (m[1]) begin exp = (f == 13) ? au13 : au15; req = "R3 auto"; end
                    else begin exp = (f == 13) ? man13 : man15; req = "R1 manual slot"; end
                    chk(req, tx_ebit, exp);
                end
        cfg_transp = 0; cfg_auto = 0; sys_ebit = 0;
        @(negedge clk);
        snap_read(v);

        // R6: exhaustive receive counting sweep
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 16; f++)
                for (int b = 0; b < 2; b++) begin
                    int exp;
                    sync_state = 2'(s); rx_fnum = 4'(f); rx_ebit = b[0];
                    rx_fstb = 1; tick(); rx_fstb = 0;
                    snap_read(v);
                    exp = (s == 2 && (f == 13 || f == 15) && b == 0) ? 1 : 0;
                    chk("R6 count qualification", v, exp);
                end

        // R8: snapshot in the same cycle as an increment
        sync_state = 2'b10; rx_fnum = 15; rx_ebit = 0;
        rx_fstb = 1; tick(); tick(); tick();
        snap = 1; tick(); snap = 0; rx_fstb = 0;
        chk("R8 snap includes same-cycle increment", err_count, 4);
        snap_read(v);
        chk("R8 running count cleared", v, 0);

        // R7: saturation
        rx_fnum = 13; rx_fstb = 1;
        repeat (CMAX + 5) tick();
        rx_fstb = 0;
        snap_read(v);
        chk("R7 saturates", v, CMAX);
        rx_fstb = 1;
        repeat (CMAX + 5) tick();
        snap = 1; tick(); snap = 0; rx_fstb = 0;
        chk("R7 saturated with same-cycle increment", err_count, CMAX);

        // R9: multiframe-begin strobes
        tx_fstb = 1; tx_fnum = 0; tick(); tx_fstb = 0;
        chk("R9 tx_mfb high", tx_mfb, 1);
        chk("R9 rx_mfb stays low", rx_mfb, 0);
        tick();
        chk("R9 tx_mfb one cycle", tx_mfb, 0);
        tx_fstb = 1; tx_fnum = 5; tick(); tx_fstb = 0;
        chk("R9 tx_mfb not on frame 5", tx_mfb, 0);
        rx_fstb = 1; rx_fnum = 0; rx_ebit = 1; tick(); rx_fstb = 0;
        chk("R9 rx_mfb high", rx_mfb, 1);
        tick();
        chk("R9 rx_mfb one cycle", rx_mfb, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule